// File: doc/BRIEF.md
# Infrared Pulse Run-Length Sampler

This block sits behind a demodulating infrared receiver and turns its raw line into a stream of run-length bytes. A free-running divider produces one sample tick every `DIV` clocks (64 by default, so an 8 MHz clock gives an 8 µs sample period). On each tick the line is sampled, optionally inverted for an active-low sensor, and passed through a glitch filter. The block then measures how many samples each filtered level lasts.

Each finished level run leaves the block as one byte. Bit 7 is the level (1 = pulse) and bits 6:0 are the length in sample periods. A packet opens at the first pulse sample. It closes when the line has stayed low for more than a programmable idle threshold. At that point the block emits the run in progress and raises a one-cycle packet-end strobe. Downstream storage and any bus or interrupt logic live outside the block.

Top module: `ir_run_sampler`

## Requirements
- R1: A synchronous active-low reset clears the divider, the filter, the run counter and all outputs (`ent_valid`, `ent_data`, `pkt_end` read 0). The filtered level starts low (idle).
- R2: The block runs only while `mode_en` and `rx_en` are both 1 and `ir_mode` equals 2'b11. In any other case the divider, filter and run state are held cleared and no entry or packet end is produced.
- R3: A sample tick occurs every `DIV` clocks while running. The first tick falls on the `DIV`-th rising edge after the block starts running.
- R4: The sampled level is `ir_in` XOR `invert`. A sampled 1 is a pulse and a sampled 0 is idle.
- R5: An entry is signalled by a one-cycle `ent_valid` in the clock cycle after the tick edge that produced it. `ent_data[7]` holds the run level and `ent_data[6:0]` holds the run length in samples.
- R6: A change of the sampled level is accepted only once the new level has been seen on `filt_thr`+1 consecutive samples. Until then, those samples count toward the current run. A shorter excursion leaves the current run unbroken.
- R7: When a run is already 127 samples long and one more sample of the same level arrives, the block emits an entry with length 127. The run then continues at the same level with length 1.
- R8: While no packet is open, low samples produce no entries. The first accepted pulse sample opens a packet with a run of length 1.
- R9: When the number of consecutive accepted low samples inside a packet exceeds `idle_thr`, the block emits the current run as it stood before that sample. It asserts `pkt_end` in the same cycle, and the closing sample belongs to no run.
- R10: After a packet end, no entry is produced until the next accepted pulse sample.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_en | input | 1 | Module enable |
| rx_en | input | 1 | Receive enable |
| ir_mode | input | 2 | Mode select; the block runs only for 2'b11 |
| invert | input | 1 | Invert the raw line before sampling |
| filt_thr | input | FILT_W | Glitch filter threshold in samples |
| idle_thr | input | IDLE_W | Idle threshold in samples |
| ir_in | input | 1 | Raw demodulated receiver line, synchronous to clk |
| ent_valid | output | 1 | Entry strobe |
| ent_data | output | 8 | Entry: level in bit 7, run length in bits 6:0 |
| pkt_end | output | 1 | Packet end strobe, coincident with the closing entry |

## Verification
A divider phase error moves every entry strobe away from its expected cycle, so the first wrong edge appears within one sample period of enabling. A wrong filter count or run counter first shows as a wrong length byte when the next level change is accepted. A stale packet state shows as a spurious entry during idle, or as a missing packet-end strobe, one idle threshold after the last pulse. The reference model tracks all of these clock by clock. Directed byte lists for the glitch, wrap, gating and zero-threshold cases confirm the hand-computed values.

// File: rtl/ir_run_pkg.sv
// Shared types and constants for the infrared run-length sampler.
package ir_run_pkg;
    localparam int LEN_W   = 7;
    localparam int RUN_MAX = (1 << LEN_W) - 1;

    typedef struct packed {
        logic             lvl;
        logic [LEN_W-1:0] len;
    } run_entry_t;
endpackage

// File: rtl/ir_tick_div.sv
// Sample tick generator.
// Produces a one-cycle tick every DIV clocks while active is high.
// Assumes DIV >= 1. The counter is held at zero while inactive or in reset.
module ir_tick_div #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

    logic [CNT_W-1:0] cnt_q;

    // Tick on the last count of each period.
    assign tick = active && (cnt_q == LAST);

    // Advance the divider, wrapping at the period end.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    generate
        if (DIV > 1) begin : g_gap
            // R3: ticks never come back to back.
            a_r3_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);
        end
    endgenerate
endmodule

// File: rtl/ir_glitch_filter.sv
// Glitch filter on the sampled line.
// A differing sample is accepted as a level change once it has been seen
// on thresh+1 consecutive ticks. level_now is the accepted level including
// the current tick and is meaningful only when tick is high.
// Assumes sample is already inverted as required.
module ir_glitch_filter #(
    parameter int FILT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              sample,
    input  logic [FILT_W-1:0] thresh,
    output logic              level_now
);
    logic              lvl_q, lvl_n;
    logic [FILT_W:0]   pend_q, pend_n;
    logic [FILT_W:0]   pend_inc;

    assign pend_inc = pend_q + 1'b1;

    // Decide whether this tick's sample confirms a level change.
    always_comb begin
        lvl_n  = lvl_q;
        pend_n = pend_q;
        if (tick) begin
            if (sample == lvl_q) begin
                pend_n = '0;
            end else if (pend_inc > {1'b0, thresh}) begin
                lvl_n  = sample;
                pend_n = '0;
            end else begin
                pend_n = pend_inc;
            end
        end
    end

    assign level_now = lvl_n;

    // Hold the accepted level and the pending-change count.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            lvl_q  <= 1'b0;
            pend_q <= '0;
        end else begin
            lvl_q  <= lvl_n;
            pend_q <= pend_n;
        end
    end

    // R6: the accepted level moves only on a sample tick.
    a_r6_level_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !tick) |=> $stable(lvl_q));
endmodule

// File: rtl/ir_run_encoder.sv
// Run-length encoder.
// On each tick it extends, splits or closes the current run of the filtered
// level. It emits registered entries and a packet-end strobe.
// Assumes level is the filtered level for the current tick.
module ir_run_encoder
    import ir_run_pkg::*;
#(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              tick,
    input  logic              level,
    input  logic [IDLE_W-1:0] idle_thr,
    output logic              ent_valid,
    output logic [7:0]        ent_data,
    output logic              pkt_end
);
    logic             in_pkt_q, in_pkt_n;
    logic             rlvl_q, rlvl_n;
    logic [LEN_W-1:0] rlen_q, rlen_n;
    logic [IDLE_W:0]  idle_q, idle_n, idle_inc;
    logic             emit, close;
    run_entry_t       ent;

    assign idle_inc = level ? '0 : (idle_q + 1'b1);

    // Next-run decision for the current tick.
    always_comb begin
        in_pkt_n = in_pkt_q;
        rlvl_n   = rlvl_q;
        rlen_n   = rlen_q;
        idle_n   = idle_q;
        emit     = 1'b0;
        close    = 1'b0;
        ent      = '{lvl: rlvl_q, len: rlen_q};
        if (tick) begin
            if (!in_pkt_q) begin
                if (level) begin
                    in_pkt_n = 1'b1;
                    rlvl_n   = 1'b1;
                    rlen_n   = LEN_W'(1);
                    idle_n   = '0;
                end
            end else if (!level && (idle_inc > {1'b0, idle_thr})) begin
                emit     = 1'b1;
                close    = 1'b1;
                in_pkt_n = 1'b0;
                rlvl_n   = 1'b0;
                rlen_n   = '0;
                idle_n   = '0;
            end else begin
                idle_n = idle_inc;
                if (level == rlvl_q) begin
                    if (rlen_q == LEN_W'(RUN_MAX)) begin
                        emit   = 1'b1;
                        rlen_n = LEN_W'(1);
                    end else begin
                        rlen_n = rlen_q + 1'b1;
                    end
                end else begin
                    emit   = 1'b1;
                    rlvl_n = level;
                    rlen_n = LEN_W'(1);
                end
            end
        end
    end

    // Run state registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            in_pkt_q <= 1'b0;
            rlvl_q   <= 1'b0;
            rlen_q   <= '0;
            idle_q   <= '0;
        end else begin
            in_pkt_q <= in_pkt_n;
            rlvl_q   <= rlvl_n;
            rlen_q   <= rlen_n;
            idle_q   <= idle_n;
        end
    end

    // Output registers for entry and packet-end strobes.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            ent_valid <= 1'b0;
            ent_data  <= '0;
            pkt_end   <= 1'b0;
        end else begin
            ent_valid <= emit;
            ent_data  <= emit ? ent : '0;
            pkt_end   <= close;
        end
    end

    // R7: an emitted run is never empty.
    a_r7_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> (ent_data[LEN_W-1:0] != '0));
    // R10: entries come only from an open packet.
    a_r10_entry_in_packet: assert property (@(posedge clk) disable iff (!rst_n)
        ent_valid |-> $past(in_pkt_q));
    // R9: a packet end leaves the packet closed.
    a_r9_end_closes: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> !in_pkt_q);
endmodule

// File: rtl/ir_run_sampler.sv
// Infrared pulse run-length sampler, top level.
// Gates the block with the enables, inverts the line if requested, and
// chains the divider, glitch filter and run encoder.
// Assumes ir_in is already synchronous to clk.
module ir_run_sampler #(
    parameter int DIV    = 64,
    parameter int FILT_W = 6,
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              rx_en,
    input  logic [1:0]        ir_mode,
    input  logic              invert,
    input  logic [FILT_W-1:0] filt_thr,
    input  logic [IDLE_W-1:0] idle_thr,
    input  logic              ir_in,
    output logic              ent_valid,
    output logic [7:0]        ent_data,
    output logic              pkt_end
);
    logic active, tick, level_now, sample;

    assign active = mode_en && rx_en && (ir_mode == 2'b11);
    assign sample = ir_in ^ invert;

    ir_tick_div #(.DIV(DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (active),
        .tick   (tick)
    );

    ir_glitch_filter #(.FILT_W(FILT_W)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick),
        .sample    (sample),
        .thresh    (filt_thr),
        .level_now (level_now)
    );

    ir_run_encoder #(.IDLE_W(IDLE_W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (active),
        .tick      (tick),
        .level     (level_now),
        .idle_thr  (idle_thr),
        .ent_valid (ent_valid),
        .ent_data  (ent_data),
        .pkt_end   (pkt_end)
    );

    // R2: nothing leaves the block the cycle after it was not running.
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!ent_valid && !pkt_end));
    // R5: a packet end always carries its closing entry.
    a_r5_end_with_entry: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> ent_valid);
endmodule

// File: tb/ir_run_sampler_test.sv
`timescale 1ns/1ps
module ir_run_sampler_test;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b0, rx_en = 1'b0, invert = 1'b0, ir_in = 1'b0;
    logic [1:0] ir_mode = 2'b00;
    logic [5:0] filt_thr = '0;
    logic [7:0] idle_thr = '0;
    logic       ent_valid, pkt_end;
    logic [7:0] ent_data;

    int checks = 0, fails = 0;
    logic [8:0] cap[$];
    logic [8:0] expq[$];

    ir_run_sampler #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .mode_en(mode_en), .rx_en(rx_en),
        .ir_mode(ir_mode), .invert(invert), .filt_thr(filt_thr),
        .idle_thr(idle_thr), .ir_in(ir_in), .ent_valid(ent_valid),
        .ent_data(ent_data), .pkt_end(pkt_end)
    );

    always #2.5 clk = ~clk;

    // Behavioural reference model state.
    int mcnt = 0, mpend = 0, rcnt = 0, icnt = 0;
    bit mlvl = 0, inpkt = 0, rlvl = 0;
    bit ev = 0, ee = 0, rst_seen = 0, act_seen = 0;
    logic [7:0] ed = '0;

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_step();
        int ni;
        bit s, act;
        act = mode_en && rx_en && (ir_mode == 2'b11);
        rst_seen = rst_n;
        act_seen = act;
        ev = 0; ee = 0; ed = '0;
        if (!rst_n || !act) begin
            mcnt = 0; mpend = 0; mlvl = 0; inpkt = 0; rlvl = 0; rcnt = 0; icnt = 0;
        end else if (mcnt == DIV - 1) begin
            mcnt = 0;
            s = ir_in ^ invert;
            if (s == mlvl) mpend = 0;
            else if (mpend + 1 > int'(filt_thr)) begin mlvl = s; mpend = 0; end
            else mpend++;
            if (!inpkt) begin
                if (mlvl) begin inpkt = 1; rlvl = 1; rcnt = 1; icnt = 0; end
            end else begin
                ni = mlvl ? 0 : icnt + 1;
                if (!mlvl && ni > int'(idle_thr)) begin
                    ev = 1; ee = 1; ed = {rlvl, 7'(rcnt)};
                    inpkt = 0; rlvl = 0; rcnt = 0; icnt = 0;
                end else begin
                    icnt = ni;
                    if (mlvl == rlvl) begin
                        if (rcnt == 127) begin ev = 1; ed = {rlvl, 7'd127}; rcnt = 1; end
                        else rcnt++;
                    end else begin
                        ev = 1; ed = {rlvl, 7'(rcnt)}; rlvl = mlvl; rcnt = 1;
                    end
                end
            end
        end else begin
            mcnt++;
        end
    endtask

    // Compare against the model every clock, then advance the model.
    always @(negedge clk) begin
        string tag;
        if (!rst_seen) tag = "R1";
        else if (!act_seen) tag = "R2";
        else if (ee) tag = "R9";
        else if (ev && ed[6:0] == 7'd127) tag = "R7";
        else tag = "R3/R5";
        check({ent_valid, pkt_end, ent_data} == {ev, ee, ed}, tag,
              int'({ent_valid, pkt_end, ent_data}), int'({ev, ee, ed}));
        if (ent_valid) cap.push_back({pkt_end, ent_data});
        model_step();
    end

    task automatic hold(bit v, int n);
        ir_in = v;
        repeat (n * DIV) @(posedge clk);
        #1;
    endtask

    task automatic check_list(string tag);
        check(cap.size() == expq.size(), tag, cap.size(), expq.size());
        if (cap.size() == expq.size())
            foreach (expq[i]) check(cap[i] == expq[i], tag, int'(cap[i]), int'(expq[i]));
        cap.delete();
        expq.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R3 watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R2: wrong mode select keeps the block quiet.
        rst_n = 1; mode_en = 1; rx_en = 1; ir_mode = 2'b10; idle_thr = 8'd3;
        hold(1, 5); hold(0, 5); hold(1, 5); hold(0, 3);
        check_list("R2");
        // R8 R10 R5: idle lead-in, runs, packet end, quiet afterwards.
        ir_mode = 2'b11;
        hold(0, 2); hold(1, 5); hold(0, 3); hold(1, 2); hold(0, 10);
        expq = '{9'h085, 9'h003, 9'h082, 9'h103};
        check_list("R8/R10");
        // R6: glitch filter with threshold 2.
        filt_thr = 6'd2;
        hold(0, 3); hold(1, 1); hold(0, 3); hold(1, 6); hold(0, 2); hold(1, 4); hold(0, 8);
        expq = '{9'h08C, 9'h103};
        check_list("R6");
        // R4 R7: inverted line, 130-sample pulse and 200-sample idle.
        filt_thr = 6'd0; idle_thr = 8'd200;
        invert = 1; ir_in = 1;
        hold(1, 2); hold(0, 130); hold(1, 208);
        expq = '{9'h0FF, 9'h083, 9'h07F, 9'h149};
        check_list("R4/R7");
        invert = 0; ir_in = 0; idle_thr = 8'd3;
        hold(0, 2);
        // R2: disabling mid-packet drops it; restart is fresh.
        hold(1, 5);
        mode_en = 0;
        repeat (20) @(posedge clk);
        #1;
        ir_in = 0;
        mode_en = 1;
        hold(0, 1); hold(1, 2); hold(0, 6);
        expq = '{9'h082, 9'h103};
        check_list("R2");
        // R9: zero idle threshold closes on the first low sample.
        idle_thr = 8'd0;
        hold(1, 3); hold(0, 3);
        expq = '{9'h183};
        check_list("R9");
        // R1: reset mid-packet clears the run.
        idle_thr = 8'd3;
        hold(1, 4);
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1; ir_in = 0;
        hold(0, 1); hold(1, 1); hold(0, 5);
        expq = '{9'h081, 9'h103};
        check_list("R1");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule